// File: doc/BRIEF.md
# Transmit Startup and Calibration Sequencer

This block takes a radio front end from standby to a transmit-ready state without any software stepping. Once `tx_request` rises, it decides whether a VCO calibration is needed, waits for the VCO bias to settle, then waits for the synthesizer loop to lock, and finally raises `tx_ready`. Both wait lengths come from one packed tune-time register. A VCO calibration is queued automatically at power-up and after each carrier frequency change. Software can also force one, or suppress the automatic one.

The same block schedules calibration of the low-power RC oscillator. A full calibration is requested at power-up because its force bit resets to one. Software can request another full calibration at any time. An optional periodic fine calibration can also be enabled. The analog engines receive level requests (`*_go`) and report completion with a one-cycle done strobe. The time base is a `tick` strobe with a 5 µs period.

Top module: `txstart_seq`

## Requirements
- R1: After reset, the tune-time register (address 0) reads 0x45, the calibration-control register (address 1) reads 0x04, and `tx_ready`, `seq_busy` and `vco_cal_go` are low.
- R2: After reset, a VCO calibration is pending. The first `tx_request` raises `vco_cal_go` one clock later. `tx_ready` stays low for any number of ticks until `vco_cal_done` is seen.
- R3: `vco_cal_done` while calibrating clears the pending flag, so a later request skips the calibration. A `freq_change` strobe sets the flag again.
- R4: Control bit 0 (skip) suppresses only the automatic calibration. Control bit 1 (force) starts a calibration even when skip is set, reads back 1 until that calibration completes, and is then cleared by hardware.
- R5: Tune bits 2:0 give the bias wait B in ticks and bits 7:3 give the lock wait L in units of 5 ticks. Counted from the start of the bias phase, `tx_ready` rises after exactly B + 5·L + 1 ticks.
- R6: Dropping `tx_request` returns the block to standby on the next clock. `tx_ready`, `seq_busy` and `vco_cal_go` go low, and the wait counters restart in full on the next request.
- R7: Control bit 2 (full RC calibration) drives `rc_full_go`. It is cleared by `rc_cal_done` and reads back the cleared value.
- R8: With control bit 3 (fine enable) set, `rc_fine_go` rises after every FINE_PERIOD_TICKS ticks and falls on `rc_cal_done`. With the bit clear it stays low.
- R9: A full RC request takes precedence: `rc_fine_go` is held low while bit 2 is set. `rc_cal_done` then retires the full request first.
- R10: Control bits 7:4 ignore writes and read 0. The tune register stores all 8 bits.
- R11: `seq_busy` is high during the calibration, bias and lock phases, and low in standby and once ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = tune time, 1 = calibration control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tick | input | 1 | 5 µs time-base strobe |
| tx_request | input | 1 | High to enter and hold transmit |
| freq_change | input | 1 | Carrier frequency changed strobe |
| vco_cal_done | input | 1 | VCO calibration finished |
| rc_cal_done | input | 1 | RC calibration finished |
| vco_cal_go | output | 1 | VCO calibration request |
| rc_full_go | output | 1 | Full RC calibration request |
| rc_fine_go | output | 1 | Fine RC calibration request |
| seq_busy | output | 1 | Startup sequence in progress |
| tx_ready | output | 1 | Transmit path settled |

## Verification
A phase counter that is off by one shows at the port as `tx_ready` rising one tick early or late. The bench counts ticks exactly for several tune settings, so this is caught. A pending-calibration flag left in the wrong state shows one clock after the next request, as `vco_cal_go` being wrong. A force bit that fails to clear is visible in the very next register read. The fine-calibration period is checked on the exact tick it should fire, and on the tick before.

// File: rtl/txs_pkg.sv
package txs_pkg;

    typedef enum logic [2:0] {
        PH_STANDBY,
        PH_VCO,
        PH_BIAS,
        PH_LOCK,
        PH_TX
    } phase_e;

    localparam int          CTRL_W   = 4;
    localparam logic [7:0]  TUNE_RST = 8'h45;
    localparam logic [CTRL_W-1:0] CTRL_RST = 4'h4;

    // control bit positions
    localparam int CB_SKIP  = 0;
    localparam int CB_FVCO  = 1;
    localparam int CB_FRC   = 2;
    localparam int CB_FINE  = 3;

    localparam logic ADDR_TUNE = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    typedef struct packed {
        logic [7:0]        tune;
        logic [CTRL_W-1:0] ctrl;
    } regs_t;

endpackage

// File: rtl/txs_regs.sv
module txs_regs
    import txs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [7:0]        wdata,
    input  logic              clr_fvco,
    input  logic              clr_frc,
    output logic [7:0]        rdata,
    output logic [7:0]        tune,
    output logic [CTRL_W-1:0] ctrl
);

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (addr == ADDR_TUNE) r_d.tune = wdata;
            else                   r_d.ctrl = wdata[CTRL_W-1:0];
        end
        // hardware completion clear wins over a same-cycle write
        if (clr_fvco) r_d.ctrl[CB_FVCO] = 1'b0;
        if (clr_frc)  r_d.ctrl[CB_FRC]  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.tune <= TUNE_RST;
            r_q.ctrl <= CTRL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign tune  = r_q.tune;
    assign ctrl  = r_q.ctrl;
    assign rdata = (addr == ADDR_TUNE) ? r_q.tune
                                       : {{(8-CTRL_W){1'b0}}, r_q.ctrl};

endmodule

// File: rtl/txs_seq.sv
module txs_seq
    import txs_pkg::*;
#(
    parameter int T0_W          = 3,
    parameter int TS_W          = 5,
    parameter int TS_UNIT_TICKS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            tx_request,
    input  logic            freq_change,
    input  logic [T0_W-1:0] bias_len,
    input  logic [TS_W-1:0] lock_len,
    input  logic            force_vco,
    input  logic            skip_auto,
    input  logic            vco_cal_done,
    output logic            vco_cal_go,
    output logic            clr_force_vco,
    output logic            tx_ready,
    output logic            seq_busy
);

    localparam int MAX_LOCK = ((1 << TS_W) - 1) * TS_UNIT_TICKS;
    localparam int MAX_BIAS = (1 << T0_W) - 1;
    localparam int MAX_CNT  = (MAX_LOCK > MAX_BIAS) ? MAX_LOCK : MAX_BIAS;
    localparam int CNT_W    = $clog2(MAX_CNT + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } seq_t;

    seq_t s_d, s_q;
    logic vco_fin;

    always_comb begin
        s_d     = s_q;
        vco_fin = (s_q.ph == PH_VCO) && vco_cal_done;

        if (vco_fin)     s_d.pend = 1'b0;
        if (freq_change) s_d.pend = 1'b1;

        if (!tx_request) begin
            s_d.ph  = PH_STANDBY;
            s_d.cnt = '0;
        end else begin
            unique case (s_q.ph)
                PH_STANDBY: begin
                    if (force_vco || (s_q.pend && !skip_auto)) begin
                        s_d.ph = PH_VCO;
                    end else begin
                        s_d.ph  = PH_BIAS;
                        s_d.cnt = CNT_W'(bias_len);
                    end
                end
                PH_VCO: begin
                    if (vco_cal_done) begin
                        s_d.ph  = PH_BIAS;
                        s_d.cnt = CNT_W'(bias_len);
                    end
                end
                PH_BIAS: begin
                    if (s_q.cnt == '0) begin
                        s_d.ph  = PH_LOCK;
                        s_d.cnt = CNT_W'(lock_len) * CNT_W'(TS_UNIT_TICKS);
                    end else if (tick) begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                PH_LOCK: begin
                    if (tick) begin
                        if (s_q.cnt == '0) s_d.ph  = PH_TX;
                        else               s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                PH_TX: s_d.ph = PH_TX;
                default: begin
                    s_d.ph  = PH_STANDBY;
                    s_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ph   <= PH_STANDBY;
            s_q.cnt  <= '0;
            s_q.pend <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign vco_cal_go    = (s_q.ph == PH_VCO);
    assign clr_force_vco = vco_fin;
    assign tx_ready      = (s_q.ph == PH_TX);
    assign seq_busy      = (s_q.ph == PH_VCO) || (s_q.ph == PH_BIAS)
                           || (s_q.ph == PH_LOCK);

endmodule

// File: rtl/txs_rc.sv
module txs_rc #(
    parameter int FINE_PERIOD_TICKS = 6_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic force_rc,
    input  logic fine_en,
    input  logic rc_cal_done,
    output logic rc_full_go,
    output logic rc_fine_go,
    output logic clr_force_rc
);

    localparam int FW = (FINE_PERIOD_TICKS > 2) ? $clog2(FINE_PERIOD_TICKS) : 1;
    localparam logic [FW-1:0] LAST = FW'(FINE_PERIOD_TICKS - 1);

    typedef struct packed {
        logic [FW-1:0] cnt;
        logic          fine_pend;
    } rc_t;

    rc_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (rc_cal_done && !force_rc) c_d.fine_pend = 1'b0;
        if (!fine_en) begin
            c_d.cnt       = '0;
            c_d.fine_pend = 1'b0;
        end else if (tick) begin
            if (c_q.cnt == LAST) begin
                c_d.cnt       = '0;
                c_d.fine_pend = 1'b1;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cnt       <= '0;
            c_q.fine_pend <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rc_full_go   = force_rc;
    assign rc_fine_go   = c_q.fine_pend && !force_rc;
    assign clr_force_rc = force_rc && rc_cal_done;

endmodule

// File: rtl/txstart_seq.sv
module txstart_seq
    import txs_pkg::*;
#(
    parameter int T0_W              = 3,
    parameter int TS_W              = 5,
    parameter int TS_UNIT_TICKS     = 5,
    parameter int FINE_PERIOD_TICKS = 6_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tick,
    input  logic       tx_request,
    input  logic       freq_change,
    input  logic       vco_cal_done,
    input  logic       rc_cal_done,
    output logic       vco_cal_go,
    output logic       rc_full_go,
    output logic       rc_fine_go,
    output logic       seq_busy,
    output logic       tx_ready
);

    logic [7:0]        tune;
    logic [CTRL_W-1:0] ctrl;
    logic              clr_fvco, clr_frc;

    txs_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .clr_fvco (clr_fvco),
        .clr_frc  (clr_frc),
        .rdata    (reg_rdata),
        .tune     (tune),
        .ctrl     (ctrl)
    );

    txs_seq #(
        .T0_W          (T0_W),
        .TS_W          (TS_W),
        .TS_UNIT_TICKS (TS_UNIT_TICKS)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .tx_request    (tx_request),
        .freq_change   (freq_change),
        .bias_len      (tune[0 +: T0_W]),
        .lock_len      (tune[T0_W +: TS_W]),
        .force_vco     (ctrl[CB_FVCO]),
        .skip_auto     (ctrl[CB_SKIP]),
        .vco_cal_done  (vco_cal_done),
        .vco_cal_go    (vco_cal_go),
        .clr_force_vco (clr_fvco),
        .tx_ready      (tx_ready),
        .seq_busy      (seq_busy)
    );

    txs_rc #(
        .FINE_PERIOD_TICKS (FINE_PERIOD_TICKS)
    ) u_rc (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .force_rc     (ctrl[CB_FRC]),
        .fine_en      (ctrl[CB_FINE]),
        .rc_cal_done  (rc_cal_done),
        .rc_full_go   (rc_full_go),
        .rc_fine_go   (rc_fine_go),
        .clr_force_rc (clr_frc)
    );

endmodule

// File: rtl/txstart_seq_chk.sv
module txstart_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic tx_request,
    input logic reg_wr_en,
    input logic rc_cal_done,
    input logic vco_cal_go,
    input logic rc_full_go,
    input logic rc_fine_go,
    input logic seq_busy,
    input logic tx_ready
);

    p_abort_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_request |=> !tx_ready);

    p_abort_vco_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_request |=> !vco_cal_go);

    p_vco_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_cal_go) |-> $past(tx_request));

    p_ready_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(tick));

    p_ready_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ready && seq_busy));

    p_rc_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rc_full_go && rc_fine_go));

    p_full_clear_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rc_full_go) |-> ($past(rc_cal_done) || $past(reg_wr_en)));

endmodule

bind txstart_seq txstart_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .tx_request  (tx_request),
    .reg_wr_en   (reg_wr_en),
    .rc_cal_done (rc_cal_done),
    .vco_cal_go  (vco_cal_go),
    .rc_full_go  (rc_full_go),
    .rc_fine_go  (rc_fine_go),
    .seq_busy    (seq_busy),
    .tx_ready    (tx_ready)
);

// File: tb/txstart_seq_tb_top.sv
module txstart_seq_tb_top;

    localparam int FINE_P = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tick = 1'b0;
    logic       tx_request = 1'b0;
    logic       freq_change = 1'b0;
    logic       vco_cal_done = 1'b0;
    logic       rc_cal_done = 1'b0;
    logic       vco_cal_go, rc_full_go, rc_fine_go, seq_busy, tx_ready;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    txstart_seq #(.FINE_PERIOD_TICKS(FINE_P)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .tick         (tick),
        .tx_request   (tx_request),
        .freq_change  (freq_change),
        .vco_cal_done (vco_cal_done),
        .rc_cal_done  (rc_cal_done),
        .vco_cal_go   (vco_cal_go),
        .rc_full_go   (rc_full_go),
        .rc_fine_go   (rc_fine_go),
        .seq_busy     (seq_busy),
        .tx_ready     (tx_ready)
    );

    // vector table for R5: bias ticks, lock units, expected tick count
    localparam int NV = 5;
    localparam int VB [NV] = '{0, 5, 7, 3, 1};
    localparam int VL [NV] = '{0, 8, 1, 31, 2};
    localparam int VE [NV] = '{1, 46, 13, 159, 12};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic a, input int exp);
        reg_addr = a;
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic tick_once();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    task automatic pulse_vco_done();
        vco_cal_done = 1'b1;
        @(negedge clk);
        vco_cal_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_rc_done();
        rc_cal_done = 1'b1;
        @(negedge clk);
        rc_cal_done = 1'b0;
    endtask

    task automatic count_to_ready(output int n);
        n = 0;
        while (!tx_ready && n < 400) begin
            tick_once();
            n++;
        end
    endtask

    task automatic request_settle();
        tx_request = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drop_request();
        tx_request = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 tune reset", 1'b0, 8'h45);
        rd_chk("R1 ctrl reset", 1'b1, 8'h04);
        chk("R1 tx_ready", int'(tx_ready), 0);
        chk("R1 seq_busy", int'(seq_busy), 0);
        chk("R1 vco_cal_go", int'(vco_cal_go), 0);

        // R7 power-up full RC calibration
        chk("R7 full go at reset", int'(rc_full_go), 1);
        pulse_rc_done();
        chk("R7 full go cleared", int'(rc_full_go), 0);
        rd_chk("R7 ctrl after done", 1'b1, 8'h00);

        // R2 power-up VCO calibration
        tx_request = 1'b1;
        @(negedge clk);
        chk("R2 vco go on first request", int'(vco_cal_go), 1);
        chk("R11 busy during vco", int'(seq_busy), 1);
        ticks(60);
        chk("R2 not ready while calibrating", int'(tx_ready), 0);
        pulse_vco_done();
        chk("R2 vco go drops", int'(vco_cal_go), 0);
        count_to_ready(n);
        chk("R5 default tick count", n, 46);
        chk("R11 not busy when ready", int'(seq_busy), 0);
        drop_request();
        chk("R6 ready drops", int'(tx_ready), 0);

        // R3 pending cleared, re-armed by freq change
        tx_request = 1'b1;
        @(negedge clk);
        chk("R3 no vco after cal", int'(vco_cal_go), 0);
        chk("R11 busy in bias", int'(seq_busy), 1);
        drop_request();
        freq_change = 1'b1;
        @(negedge clk);
        freq_change = 1'b0;
        tx_request = 1'b1;
        @(negedge clk);
        chk("R3 vco after freq change", int'(vco_cal_go), 1);
        pulse_vco_done();
        drop_request();

        // R5 vector table
        for (int v = 0; v < NV; v++) begin
            wr(1'b0, {VL[v][4:0], VB[v][2:0]});
            request_settle();
            count_to_ready(n);
            chk($sformatf("R5 vector %0d ticks", v), n, VE[v]);
            drop_request();
        end

        // R6 abort mid-lock restarts counters
        wr(1'b0, 8'h45);
        request_settle();
        ticks(10);
        drop_request();
        chk("R6 busy drops on abort", int'(seq_busy), 0);
        request_settle();
        count_to_ready(n);
        chk("R6 full count after abort", n, 46);
        drop_request();

        // R4 skip and force
        wr(1'b1, 8'h01);
        freq_change = 1'b1;
        @(negedge clk);
        freq_change = 1'b0;
        tx_request = 1'b1;
        @(negedge clk);
        chk("R4 skip suppresses auto", int'(vco_cal_go), 0);
        drop_request();
        wr(1'b1, 8'h03);
        rd_chk("R4 force reads 1", 1'b1, 8'h03);
        tx_request = 1'b1;
        @(negedge clk);
        chk("R4 force overrides skip", int'(vco_cal_go), 1);
        pulse_vco_done();
        rd_chk("R4 force self-clears", 1'b1, 8'h01);
        drop_request();
        wr(1'b1, 8'h00);
        tx_request = 1'b1;
        @(negedge clk);
        chk("R3 forced cal cleared pending", int'(vco_cal_go), 0);
        drop_request();

        // R10 register widths
        wr(1'b1, 8'hF0);
        rd_chk("R10 ctrl upper bits", 1'b1, 8'h00);
        wr(1'b0, 8'hA7);
        rd_chk("R10 tune full byte", 1'b0, 8'hA7);
        wr(1'b0, 8'h45);

        // R8 periodic fine calibration
        wr(1'b1, 8'h08);
        ticks(FINE_P - 1);
        chk("R8 fine not yet", int'(rc_fine_go), 0);
        tick_once();
        chk("R8 fine on period", int'(rc_fine_go), 1);
        pulse_rc_done();
        chk("R8 fine cleared", int'(rc_fine_go), 0);
        wr(1'b1, 8'h00);
        ticks(FINE_P + 5);
        chk("R8 fine disabled", int'(rc_fine_go), 0);

        // R9 full over fine
        wr(1'b1, 8'h08);
        ticks(FINE_P);
        chk("R9 fine pending", int'(rc_fine_go), 1);
        wr(1'b1, 8'h0C);
        chk("R9 full asserted", int'(rc_full_go), 1);
        chk("R9 fine masked", int'(rc_fine_go), 0);
        pulse_rc_done();
        chk("R9 full retired first", int'(rc_full_go), 0);
        chk("R9 fine resumes", int'(rc_fine_go), 1);
        pulse_rc_done();
        chk("R9 fine retired", int'(rc_fine_go), 0);

        finish_run();
    end

endmodule